// File: doc/BRIEF.md
# Integer-Ratio Sync Enable Generator

This block runs entirely on the fast clock and tracks the phase of two slower clock domains whose periods are integer multiples of the fast period. One is the main slow domain. The other is a second slow domain with its own ratio, intended to run at twice the main slow rate. For each domain a phase counter walks from 0 to ratio-1. A decoded indicator shows where that domain's clock is high.

From these counters the block makes three one-cycle enables. Logic uses them to move data between the fast and slow domains in either direction and into the second slow domain. Each enable sits at a fixed phase of its period, and the two crossing directions use different phases. A test-mode input moves the slow-to-fast pulse so that it lands, one flop stage later, just before the next slow rising edge. A select input makes the fast-to-slow output carry the second domain's enable instead.

A synchronous stop input and the active-low asynchronous reset both clear the counters and silence every output. Phase counting restarts at phase 0 once both are released. The divide ratios are captured only on clock edges that see reset low.

Top module: `sen_sync_gen`

## Requirements
- R1: Counting from the first cycle after reset and stop are both released (phase 0), `slow_clk_o` is high for phases 0 to floor(N/2)-1 of each N-cycle period and low otherwise. `dbl_clk_o` behaves the same way with the second ratio Nd.
- R2: Each enable is high for exactly one fast cycle, once per period of its domain, with exactly ratio-1 low cycles between consecutive pulses.
- R3: With `f2s_use_dbl_i` low, `f2s_en_o` is high at phase (floor(N/2)+2) mod N. That is two fast cycles after the slow clock falls.
- R4: With `test_mode_i` low, `s2f_en_o` is high at phase 2 mod N. That is two fast cycles after the slow clock rises.
- R5: With `test_mode_i` high, `s2f_en_o` is high at phase N-2.
- R6: `dbl_en_o` is high at phase (floor(Nd/2)+1) mod Nd of the second domain. That is one fast cycle after that clock falls.
- R7: With `f2s_use_dbl_i` high, `f2s_en_o` equals `dbl_en_o` on every cycle.
- R8: While `rst_ni` is low or `stop_i` is sampled high, all five outputs are low on the following cycle. The next running cycle is phase 0 of both domains.
- R9: A ratio is captured only on rising edges that see `rst_ni` low. A ratio input change while out of reset has no effect until the next reset.
- R10: A ratio below 2 is used as 2, and a ratio above 16 is used as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low; ratios are captured while low |
| stop_i | input | 1 | Clock-stop request, sampled on the fast clock |
| ratio_i | input | 5 | Main slow domain divide ratio |
| dbl_ratio_i | input | 5 | Second slow domain divide ratio |
| test_mode_i | input | 1 | Moves the slow-to-fast pulse to phase N-2 |
| f2s_use_dbl_i | input | 1 | Routes the second domain's enable onto `f2s_en_o` |
| slow_clk_o | output | 1 | Main slow clock phase indicator |
| dbl_clk_o | output | 1 | Second slow clock phase indicator |
| f2s_en_o | output | 1 | Fast-to-slow sync enable |
| s2f_en_o | output | 1 | Slow-to-fast sync enable |
| dbl_en_o | output | 1 | Second-domain sync enable |

## Verification
On every cycle the embedded properties check the following:
- each enable is a single-cycle pulse whose spacing equals the captured ratio;
- each phase counter stays below its ratio and wraps to zero;
- stop clears the counters and outputs, and a release restarts at phase 0;
- the captured ratio never changes outside reset.

Where each pulse sits inside the period, and how that placement depends on test mode and the output select, can only be shown by the bench's scenarios. The same holds for the clamping of out-of-range ratios and for ignoring ratio changes at run time. The bench compares all five outputs cycle by cycle against a phase model built from the requirements.

// File: rtl/sen_pkg.sv
package sen_pkg;

   typedef enum logic [1:0] {
      TAP_F2S = 2'd0,
      TAP_S2F = 2'd1,
      TAP_DBL = 2'd2
   } tap_kind_e;

   // limit a requested ratio to the supported range
   function automatic int clamp_ratio(int req, int lo, int hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

   // (base + off) modulo n, for base < n and small off
   function automatic int wrap_phase(int base, int off, int n);
      int t;
      t = base + off;
      if (t >= n) t = t - n;
      if (t >= n) t = t - n;
      return t;
   endfunction

endpackage

// File: rtl/sen_phase_ctr.sv
module sen_phase_ctr #(
   parameter int RATIO_W   = 5,
   parameter int MIN_RATIO = 2,
   parameter int MAX_RATIO = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               stop_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               run_o,
   output logic [RATIO_W-1:0] ph_o,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               phase_hi_o
);

   localparam logic [RATIO_W-1:0] LastOff = RATIO_W'(1);

   if (MIN_RATIO < 2 || MAX_RATIO < MIN_RATIO || MAX_RATIO >= (1 << RATIO_W)) begin : g_bad_cfg
      $error("sen_phase_ctr: ratio range does not fit RATIO_W");
   end

   logic [RATIO_W-1:0] ratio_q;
   logic [RATIO_W-1:0] ph_q;
   logic               run_q;
   logic [RATIO_W-1:0] half;

   // ratio capture: loads only on edges that see reset low
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ratio_q <= RATIO_W'(sen_pkg::clamp_ratio(int'(ratio_i), MIN_RATIO, MAX_RATIO));
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         ph_q  <= '0;
      end else if (stop_i) begin
         run_q <= 1'b0;
         ph_q  <= '0;
      end else begin
         run_q <= 1'b1;
         if (run_q) begin
            ph_q <= (ph_q == ratio_q - LastOff) ? '0 : ph_q + LastOff;
         end
      end
   end

   assign half       = ratio_q >> 1;
   assign run_o      = run_q;
   assign ph_o       = ph_q;
   assign ratio_o    = ratio_q;
   assign phase_hi_o = run_q && (ph_q < half);

   // R9
   ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> $stable(ratio_q));

   // R1
   ph_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ph_q < ratio_q);

   // R8
   stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!run_q && ph_q == '0));

   // R8
   restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !stop_i) |=> (run_q && ph_q == '0));

endmodule

// File: rtl/sen_pulse_tap.sv
module sen_pulse_tap #(
   parameter int                 RATIO_W = 5,
   parameter sen_pkg::tap_kind_e KIND    = sen_pkg::TAP_F2S
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic [RATIO_W-1:0] ph_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               test_mode_i,
   output logic               pulse_o
);

   logic [RATIO_W-1:0] tgt;
   int                 n;

   assign n = int'(ratio_i);

   if (KIND == sen_pkg::TAP_F2S) begin : g_f2s
      // two fast cycles after the slow clock falls
      assign tgt = RATIO_W'(sen_pkg::wrap_phase(n / 2, 2, n));
   end else if (KIND == sen_pkg::TAP_S2F) begin : g_s2f
      // two cycles after the rise, or one cycle before the next rise after a flop
      assign tgt = test_mode_i ? RATIO_W'(sen_pkg::wrap_phase(n - 2, 0, n))
                               : RATIO_W'(sen_pkg::wrap_phase(0, 2, n));
   end else begin : g_dbl
      // one fast cycle after the second-domain clock falls
      assign tgt = RATIO_W'(sen_pkg::wrap_phase(n / 2, 1, n));
   end

   assign pulse_o = run_i && (ph_i == tgt);

   // spacing monitor for the checks below
   logic [RATIO_W:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (!run_i) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (pulse_o) begin
         gap_q  <= (RATIO_W + 1)'(1);
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + (RATIO_W + 1)'(1);
      end
   end

   // R2
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o);

   // R2
   pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_o && seen_q) |-> (gap_q == {1'b0, ratio_i}));

endmodule

// File: rtl/sen_sync_gen.sv
module sen_sync_gen #(
   parameter int RATIO_W   = 5,
   parameter int MIN_RATIO = 2,
   parameter int MAX_RATIO = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               stop_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic [RATIO_W-1:0] dbl_ratio_i,
   input  logic               test_mode_i,
   input  logic               f2s_use_dbl_i,
   output logic               slow_clk_o,
   output logic               dbl_clk_o,
   output logic               f2s_en_o,
   output logic               s2f_en_o,
   output logic               dbl_en_o
);

   logic               slow_run, dbl_run;
   logic [RATIO_W-1:0] slow_ph, dbl_ph;
   logic [RATIO_W-1:0] slow_n, dbl_n;
   logic               f2s_pulse, s2f_pulse, dbl_pulse;

   sen_phase_ctr #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO)) u_slow_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stop_i     (stop_i),
      .ratio_i    (ratio_i),
      .run_o      (slow_run),
      .ph_o       (slow_ph),
      .ratio_o    (slow_n),
      .phase_hi_o (slow_clk_o)
   );

   sen_phase_ctr #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO)) u_dbl_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stop_i     (stop_i),
      .ratio_i    (dbl_ratio_i),
      .run_o      (dbl_run),
      .ph_o       (dbl_ph),
      .ratio_o    (dbl_n),
      .phase_hi_o (dbl_clk_o)
   );

   sen_pulse_tap #(.RATIO_W(RATIO_W), .KIND(sen_pkg::TAP_F2S)) u_f2s_tap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (slow_run),
      .ph_i        (slow_ph),
      .ratio_i     (slow_n),
      .test_mode_i (test_mode_i),
      .pulse_o     (f2s_pulse)
   );

   sen_pulse_tap #(.RATIO_W(RATIO_W), .KIND(sen_pkg::TAP_S2F)) u_s2f_tap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (slow_run),
      .ph_i        (slow_ph),
      .ratio_i     (slow_n),
      .test_mode_i (test_mode_i),
      .pulse_o     (s2f_pulse)
   );

   sen_pulse_tap #(.RATIO_W(RATIO_W), .KIND(sen_pkg::TAP_DBL)) u_dbl_tap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (dbl_run),
      .ph_i        (dbl_ph),
      .ratio_i     (dbl_n),
      .test_mode_i (test_mode_i),
      .pulse_o     (dbl_pulse)
   );

   assign f2s_en_o = f2s_use_dbl_i ? dbl_pulse : f2s_pulse;
   assign s2f_en_o = s2f_pulse;
   assign dbl_en_o = dbl_pulse;

   // R8
   stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> !(slow_clk_o || dbl_clk_o || f2s_en_o || s2f_en_o || dbl_en_o));

   // R2
   enables_onehot_s2f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s2f_en_o |=> !s2f_en_o);

endmodule

// File: tb/sen_sync_gen_tb_top.sv
module sen_sync_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop = 1'b0;
   logic [4:0] ratio = 5'd4;
   logic [4:0] dbl_ratio = 5'd2;
   logic       test_mode = 1'b0;
   logic       use_dbl = 1'b0;
   logic       slow_clk, dbl_clk, f2s_en, s2f_en, dbl_en;

   always #2.5 clk = ~clk;

   sen_sync_gen dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .stop_i        (stop),
      .ratio_i       (ratio),
      .dbl_ratio_i   (dbl_ratio),
      .test_mode_i   (test_mode),
      .f2s_use_dbl_i (use_dbl),
      .slow_clk_o    (slow_clk),
      .dbl_clk_o     (dbl_clk),
      .f2s_en_o      (f2s_en),
      .s2f_en_o      (s2f_en),
      .dbl_en_o      (dbl_en)
   );

   typedef struct {
      bit    slow;
      bit    dclk;
      bit    f2s;
      bit    s2f;
      bit    dbl;
      string tag;
   } exp_t;

   exp_t  sb_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   int    mn, md, k, kd;
   bit    started;
   string scen = "R2";

   function automatic int lim(int r);
      if (r < 2) return 2;
      if (r > 16) return 16;
      return r;
   endfunction

   task automatic push_idle();
      exp_t e;
      e.slow = 0; e.dclk = 0; e.f2s = 0; e.s2f = 0; e.dbl = 0;
      e.tag = "R8";
      started = 0;
      sb_q.push_back(e);
   endtask

   task automatic push_run();
      exp_t e;
      bit   f2s_main, dbl_p;
      if (!started) begin
         started = 1; k = 0; kd = 0;
      end else begin
         k  = (k + 1) % mn;
         kd = (kd + 1) % md;
      end
      e.slow   = (k < mn / 2);
      e.dclk   = (kd < md / 2);
      f2s_main = (k == (mn / 2 + 2) % mn);
      dbl_p    = (kd == (md / 2 + 1) % md);
      e.dbl    = dbl_p;
      e.f2s    = use_dbl ? dbl_p : f2s_main;
      e.s2f    = test_mode ? (k == mn - 2) : (k == 2 % mn);
      e.tag    = scen;
      sb_q.push_back(e);
   endtask

   task automatic do_reset(int r, int rd, bit tm, bit ud, string tg);
      scen = tg;
      @(negedge clk); #1;
      rst_n = 0; stop = 0;
      ratio = 5'(r); dbl_ratio = 5'(rd); test_mode = tm; use_dbl = ud;
      mn = lim(r); md = lim(rd);
      push_idle();
      repeat (2) begin
         @(negedge clk); #1;
         push_idle();
      end
      @(negedge clk); #1;
      rst_n = 1;
      push_run();
   endtask

   task automatic run(int n);
      repeat (n) begin
         @(negedge clk); #1;
         push_run();
      end
   endtask

   task automatic hold_stop(int n);
      @(negedge clk); #1;
      stop = 1;
      push_idle();
      repeat (n - 1) begin
         @(negedge clk); #1;
         push_idle();
      end
      @(negedge clk); #1;
      stop = 0;
      push_run();
   endtask

   task automatic chk(bit act, bit expv, string req, string what, string tg);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s (%s) %s: actual %0b expected %0b at %0t", req, tg, what, act, expv, $time);
      end
   endtask

   // monitor: compares one expected item per cycle, away from the rising edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk(slow_clk, e.slow, "R1", "slow_clk_o", e.tag);
         chk(dbl_clk,  e.dclk, "R1", "dbl_clk_o",  e.tag);
         chk(f2s_en,   e.f2s,  use_dbl ? "R7" : "R3", "f2s_en_o", e.tag);
         chk(s2f_en,   e.s2f,  test_mode ? "R5" : "R4", "s2f_en_o", e.tag);
         chk(dbl_en,   e.dbl,  "R6", "dbl_en_o", e.tag);
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R2 R3 R4 R6: basic spacing and phases
      do_reset(4, 2, 0, 0, "R2");
      run(24);
      // R5: test-mode slow-to-fast placement
      do_reset(5, 3, 1, 0, "R5");
      run(30);
      // R7: fast-to-slow output carries the second-domain enable
      do_reset(2, 4, 1, 1, "R7");
      run(20);
      do_reset(7, 5, 0, 1, "R7");
      run(30);
      // R10: clamping on both ends
      do_reset(0, 1, 0, 0, "R10");
      run(12);
      do_reset(20, 31, 0, 0, "R10");
      run(40);
      // R8: stop mid-period restarts at phase zero
      do_reset(6, 3, 0, 0, "R8");
      run(9);
      hold_stop(4);
      run(20);
      // R9: ratio change out of reset is ignored
      scen = "R9";
      @(negedge clk); #1;
      ratio = 5'd3; dbl_ratio = 5'd9;
      push_run();
      run(24);
      // R3: odd ratio placement
      do_reset(9, 4, 0, 0, "R3");
      run(30);
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule